// File: doc/BRIEF.md
# E1 National Bit Extractor

This block sits behind the frame aligner of an E1 receiver and copies the national bits out of the received stream onto a serial overhead port. The national bits are Sa4 to Sa8. They occupy bit positions 4 to 8 of timeslot 0 in the frames that do not carry the frame alignment word. A five-bit selection held in a small parallel-write register decides which of those positions carry data-link information. Each selected bit appears on the overhead data line and is followed by one overhead clock pulse. A downstream data-link device latches the data on the rising edge of that pulse.

The receive path runs in the system clock domain. Each received bit arrives with a one-cycle strobe. The aligner also supplies a frame-start marker on the first bit of each frame, a level that says whether the starting frame is a non-alignment frame, and a sync-valid level. Extraction runs whenever sync is valid. It does not depend on any data-link controller further on.

Top module: `e1_sa_extract`

## Requirements
- R1: After reset, oh_clk and oh_data are 0, cfg_rdata reads 0x00 and no national bit is extracted until a selection has been written and committed.
- R2: Select bit 3+k (k = 0..4) enables Sa(4+k). Sa(4+k) is bit position 4+k of timeslot 0, where bit 1 is the bit strobed together with rx_frame_start. Selected bits leave in the order Sa4 first, Sa8 last.
- R3: Exactly one oh_clk pulse is produced for each received Sa bit whose select bit is set, and none for any other bit.
- R4: A selected bit is sampled on the clock edge where rx_bit_en is high. oh_data takes its value after that edge with oh_clk low. oh_clk is high for the next cycle only. The data is therefore stable for a full cycle before the rising edge of oh_clk.
- R5: Frames that start with rx_nfas = 0 (alignment frames) produce no pulses, whatever the selection.
- R6: A write to the selection takes effect at the next frame start with rx_nfas = 1. Until then the previous selection governs every bit, including the rest of the current frame. A write in the same cycle as such a boundary waits for the following one.
- R7: While rx_sync is 0, oh_clk stays 0 and oh_data is driven 0 from the next cycle. After sync returns, extraction resumes only at the next frame start.
- R8: cfg_rdata returns the written selection in bits 7..3, and bits 2..0 always read 0.
- R9: With an all-zero committed selection, no pulse is produced and oh_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_en | input | 1 | One-cycle strobe qualifying rx_bit |
| rx_frame_start | input | 1 | With rx_bit_en, marks bit 1 of timeslot 0 |
| rx_nfas | input | 1 | At frame start, 1 if this frame lacks the alignment word |
| rx_sync | input | 1 | Frame alignment valid |
| cfg_we | input | 1 | Selection register write strobe |
| cfg_wdata | input | 8 | Selection write data (bits 7..3 used) |
| cfg_rdata | output | 8 | Selection readback, bits 2..0 zero |
| oh_data | output | 1 | Serial overhead data |
| oh_clk | output | 1 | Overhead clock, one pulse per selected bit |

## Verification
The bench targets the off-by-one risk in the slot position. A design that counted from the wrong bit would emit the neighbouring bits 3 or 9, which shows up as wrong captured data under asymmetric masks and patterns. A selection written in the middle of a non-alignment frame must leave that frame untouched: a design that committed at once would emit a partial set of bits. Alignment frames with a full mask must stay silent, and the exact cycle of data and clock is probed to catch a clock that rises with the data instead of after it. Sync is dropped in the middle of a frame and then restored in the middle of a frame, which catches designs that keep pulsing or resume before the next frame start.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int SA_NUM      = 5;   // Sa4..Sa8
  localparam int SA_FIRST    = 3;   // zero-based position of Sa4 within the frame
  localparam int REG_W       = 8;
  localparam int SEL_LSB     = 3;   // register bit that enables Sa4
  localparam logic [REG_W-1:0] SEL_KEEP = 8'hF8;
  typedef logic [SA_NUM-1:0] sa_mask_t;
endpackage

// File: rtl/e1_sa_cfg.sv
module e1_sa_cfg
  import e1_sa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             commit,
  output logic [REG_W-1:0] rdata,
  output sa_mask_t         active
);
  logic [REG_W-1:0] pend_q;
  sa_mask_t         act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (we)     pend_q <= wdata & SEL_KEEP;
      if (commit) act_q  <= pend_q[SEL_LSB +: SA_NUM];
    end
  end

  assign rdata  = pend_q;
  assign active = act_q;

  // R6: the working selection only moves at a non-alignment frame boundary
  a_r6_commit_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(commit));
endmodule

// File: rtl/e1_sa_locator.sv
module e1_sa_locator
  import e1_sa_pkg::*;
#(
  parameter int FRAME_BITS = 256
)(
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_en,
  input  logic     frame_start,
  input  logic     nfas,
  input  logic     sync,
  input  sa_mask_t mask,
  output logic     hit,
  output logic     commit
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] POS_MAX = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt_q, pos;
  logic             nfas_q, framed_q;
  logic             cur_nfas, cur_framed;
  sa_mask_t         slot;

  assign pos        = frame_start ? '0 : cnt_q;
  assign cur_nfas   = frame_start ? nfas : nfas_q;
  assign cur_framed = frame_start | framed_q;
  assign commit     = bit_en & frame_start & nfas;

  for (genvar k = 0; k < SA_NUM; k++) begin : g_slot
    assign slot[k] = (pos == CNT_W'(SA_FIRST + k));
  end

  assign hit = bit_en & sync & cur_framed & cur_nfas & |(slot & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      nfas_q   <= 1'b0;
      framed_q <= 1'b0;
    end else begin
      if (!sync) framed_q <= 1'b0;
      else if (bit_en && frame_start) framed_q <= 1'b1;
      if (bit_en) begin
        nfas_q <= cur_nfas;
        if (pos != POS_MAX) cnt_q <= pos + 1'b1;
        else                cnt_q <= pos;
      end
    end
  end

  // R9: an empty selection can never produce an extraction
  a_r9_empty_mask_silent: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> !hit);
endmodule

// File: rtl/e1_sa_serial_out.sv
module e1_sa_serial_out (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic bit_in,
  input  logic sync,
  output logic oh_data,
  output logic oh_clk
);
  logic ph_q, clk_q, dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 1'b0;
      clk_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      ph_q  <= hit;
      clk_q <= ph_q & sync;
      if (!sync)    dat_q <= 1'b0;
      else if (hit) dat_q <= bit_in;
    end
  end

  assign oh_data = dat_q;
  assign oh_clk  = clk_q;

  // R3: every rising overhead clock traces back to one extracted bit
  a_r3_pulse_from_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_q) |-> $past(hit, 2));
  // R4: data has settled one cycle before the clock rises
  a_r4_data_settled: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_q) |-> $stable(dat_q));
  // R7: loss of sync silences both lines
  a_r7_quiet_on_loss: assert property (@(posedge clk) disable iff (rst)
    !sync |=> (!clk_q && !dat_q));
endmodule

// File: rtl/e1_sa_extract.sv
module e1_sa_extract
  import e1_sa_pkg::*;
#(
  parameter int FRAME_BITS = 256
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  input  logic             rx_bit_en,
  input  logic             rx_frame_start,
  input  logic             rx_nfas,
  input  logic             rx_sync,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             oh_data,
  output logic             oh_clk
);
  sa_mask_t active;
  logic     hit, commit;

  e1_sa_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .commit(commit), .rdata(cfg_rdata), .active(active)
  );

  e1_sa_locator #(.FRAME_BITS(FRAME_BITS)) u_loc (
    .clk(clk), .rst(rst), .bit_en(rx_bit_en), .frame_start(rx_frame_start),
    .nfas(rx_nfas), .sync(rx_sync), .mask(active), .hit(hit), .commit(commit)
  );

  e1_sa_serial_out u_out (
    .clk(clk), .rst(rst), .hit(hit), .bit_in(rx_bit), .sync(rx_sync),
    .oh_data(oh_data), .oh_clk(oh_clk)
  );
endmodule

// File: tb/sim_e1_sa_extract.sv
`timescale 1ns/1ps
module sim_e1_sa_extract;
  logic clk = 0, rst = 1;
  logic rx_bit = 0, rx_bit_en = 0, rx_frame_start = 0, rx_nfas = 0, rx_sync = 1;
  logic cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic oh_data, oh_clk;
  int checks = 0, errors = 0;
  logic prev_clk = 0;
  int cap_n = 0;
  logic [15:0] cap_bits;
  bit done = 0;

  always #4 clk = ~clk;

  e1_sa_extract u0 (.*);

  always @(negedge clk) begin
    if (oh_clk && !prev_clk) begin
      if (cap_n < 16) cap_bits[cap_n] <= oh_data;
      cap_n <= cap_n + 1;
    end
    prev_clk <= oh_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send_bit(input logic b, input logic fs, input logic nf);
    @(negedge clk);
    rx_bit = b; rx_bit_en = 1; rx_frame_start = fs; rx_nfas = nf;
    @(negedge clk);
    rx_bit_en = 0; rx_frame_start = 0;
    repeat (2) @(negedge clk);
  endtask

  // 16-bit frame head; ts0[7] is bit 1. Optional write / sync drop at a bit index.
  task automatic run_frame(input logic nf, input logic [7:0] ts0,
                           input int wr_at, input logic [7:0] wr_val,
                           input int drop_at, input int back_at);
    for (int i = 1; i <= 16; i++) begin
      if (i == drop_at) rx_sync = 0;
      if (i == back_at) rx_sync = 1;
      if (i == wr_at) cfg_write(wr_val);
      send_bit(i <= 8 ? ts0[8-i] : logic'(i % 2), i == 1, nf);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_seq(input logic [7:0] mask, input logic [7:0] ts0, input string req);
    int n = 0;
    logic [15:0] e = '0;
    for (int k = 0; k < 5; k++)
      if (mask[3+k]) begin e[n] = ts0[4-k]; n++; end
    chk(cap_n == n, req, cap_n, n);
    chk((cap_bits & ((16'd1 << n) - 1)) == e, req, int'(cap_bits & ((16'd1 << n) - 1)), int'(e));
  endtask

  task automatic t_reset;
    chk(oh_clk == 0 && oh_data == 0, "R1", {oh_clk, oh_data}, 0);
    chk(cfg_rdata == 8'h00, "R1", cfg_rdata, 0);
  endtask

  task automatic t_empty;           // R9 and R1: nothing committed yet
    cap_n = 0;
    run_frame(1, 8'hFF, 0, 0, 0, 0);
    chk(cap_n == 0, "R9", cap_n, 0);
    chk(oh_data == 0, "R9", oh_data, 0);
  endtask

  task automatic t_readback;        // R8
    cfg_write(8'hFF);
    @(negedge clk);
    chk(cfg_rdata == 8'hF8, "R8", cfg_rdata, 8'hF8);
  endtask

  task automatic t_commit_and_fas;  // R6, R5
    cap_n = 0;
    run_frame(0, 8'hFF, 0, 0, 0, 0);
    chk(cap_n == 0, "R6 fas frame no commit", cap_n, 0);
    cap_n = 0;
    run_frame(1, 8'h1F, 0, 0, 0, 0);
    expect_seq(8'hF8, 8'h1F, "R6 commit at nfas");
    cap_n = 0;
    run_frame(0, 8'hFF, 0, 0, 0, 0);
    chk(cap_n == 0, "R5", cap_n, 0);
  endtask

  task automatic t_defer;           // R6: mid-frame write does not touch the current frame
    cap_n = 0;
    run_frame(1, 8'h15, 2, 8'h08, 0, 0);
    expect_seq(8'hF8, 8'h15, "R6 old mask rest of frame");
    cap_n = 0;
    run_frame(1, 8'h1A, 0, 0, 0, 0);
    expect_seq(8'h08, 8'h1A, "R6 new mask next frame");
  endtask

  task automatic t_masks;           // R2, R3
    logic [7:0] m [5] = '{8'h08, 8'h80, 8'hA8, 8'h50, 8'hF8};
    logic [7:0] d [5] = '{8'hF7, 8'hE1, 8'h15, 8'h0A, 8'hE6};
    for (int j = 0; j < 5; j++) begin
      cfg_write(m[j]);
      run_frame(0, 8'h00, 0, 0, 0, 0);
      cap_n = 0;
      run_frame(1, d[j], 0, 0, 0, 0);
      expect_seq(m[j], d[j], j[0] ? "R2" : "R3");
    end
  endtask

  task automatic t_timing;          // R4
    cfg_write(8'h08);
    run_frame(1, 8'h00, 0, 0, 0, 0);  // commit, Sa4 = 0
    send_bit(0, 1, 1);
    send_bit(0, 0, 1);
    send_bit(0, 0, 1);
    @(negedge clk); rx_bit = 1; rx_bit_en = 1;
    @(negedge clk); rx_bit_en = 0;
    chk(oh_data == 1 && oh_clk == 0, "R4 data first", {oh_data, oh_clk}, 2);
    @(negedge clk);
    chk(oh_clk == 1 && oh_data == 1, "R4 clock high", {oh_data, oh_clk}, 3);
    @(negedge clk);
    chk(oh_clk == 0, "R4 clock one cycle", oh_clk, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_sync;            // R7
    cfg_write(8'hF8);
    run_frame(1, 8'h00, 0, 0, 0, 0);
    cap_n = 0;
    run_frame(1, 8'hFF, 0, 0, 2, 0);
    chk(cap_n == 0, "R7 no pulses", cap_n, 0);
    chk(oh_data == 0, "R7 data low", oh_data, 0);
    cap_n = 0;
    run_frame(1, 8'hFF, 0, 0, 0, 3);
    chk(cap_n == 0, "R7 waits for frame start", cap_n, 0);
    cap_n = 0;
    run_frame(1, 8'h19, 0, 0, 0, 0);
    expect_seq(8'hF8, 8'h19, "R7 resumes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_empty();
    t_readback();
    t_commit_and_fas();
    t_defer();
    t_masks();
    t_timing();
    t_sync();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule